// File: doc/BRIEF.md
# Dual-Unit Dispatch Interlock with Precise Traps

This block sits between an in-order decoder and two execution queues, one for a fixed-point unit and one for a floating-point unit. It takes one decoded instruction per cycle over a valid/ready stream. Each instruction carries a class code, an opaque payload and a may-trap flag. The block routes the instruction to the right unit and enforces the rules that keep interrupts precise without a result buffer. All loads, including floating-point loads, go through the fixed-point unit, and a load occupies that unit for a fixed number of cycles. Floating-point work waits while any older trap-capable fixed-point instruction is still unresolved.

Each trap-capable fixed-point instruction receives a sequence tag when it is dispatched. Execution returns resolutions for those tags in any order. The block reports them strictly in tag order, one per cycle. A report that carries a trap flushes every younger instruction in the same cycle and halts dispatch until a restart acknowledge arrives. Back-pressure works in the usual way: the input is taken only in a cycle where `in_valid` and `in_ready` are both high. Each unit output raises valid on its own and waits for that unit's ready. A stall-cause vector shows which rule blocks the instruction in each cycle.

Top module: `dui_dispatch`

## Requirements
- R1: Class 0 (fixed-point ALU) and class 1 (load) go to the fixed-point output, and class 2 (floating-point arithmetic) goes to the floating-point output. At most one of `fx_valid` and `fp_valid` is high in any cycle, so at most one fixed-point arithmetic instruction is dispatched per cycle. The payload appears unchanged on the chosen output.
- R2: A class 1 instruction never raises `fp_valid`. On the fixed-point output, `fx_load` is high exactly when the instruction is class 1.
- R3: After a load is accepted by the fixed-point unit, `fx_valid` stays low for the next LD_CYC-1 cycles. During those cycles a fixed-point-bound input sets `stall[1]`.
- R4: While one or more dispatched trap-capable fixed-point instructions are unreported, `fp_valid` is low and a waiting class 2 input sets `stall[0]`. The hold ends in the cycle after the last pending instruction is reported.
- R5: If nothing is pending, a class 2 instruction is accepted in the first cycle `fp_ready` is high, even while the fixed-point unit is busy with a load.
- R6: A resolution for a pending tag shows up on `rpt_valid` one cycle later at the earliest. Reports come out in dispatch order, one per cycle, and a resolution for a younger tag is held until all older tags are reported. A resolution naming a tag that is not pending is ignored.
- R7: A report with `rpt_trap` high raises `flush` in that same cycle. That cycle dispatches nothing. From the next cycle `halted` is high and `in_ready` is low until a cycle with `restart_ack` high. All pending tags are discarded.
- R8: Only fixed-point instructions with the may-trap flag receive a tag. Tags count up modulo 2^TAG_W, and the current tag is shown on `fx_tag`. With 2^TAG_W tags pending, a trap-capable fixed-point instruction is held and sets `stall[2]`. `stall[2]` is also set when the target unit's ready is low.
- R9: `fx_valid` and `fp_valid` never depend on the ready inputs. `in_ready` is high only when the chosen output is valid and its ready is high.
- R10: `stall` is all zeros whenever `in_valid` is low, `halted` is high or `flush` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction accepted this cycle |
| in_cls | input | 2 | Class: 0 ALU, 1 load, 2 FP arithmetic (3 treated as ALU) |
| in_trap | input | 1 | Instruction may raise an interrupt |
| in_op | input | OP_W | Opaque payload |
| fx_valid | output | 1 | Instruction offered to the fixed-point queue |
| fx_ready | input | 1 | Fixed-point queue can accept |
| fx_load | output | 1 | Offered instruction is a load |
| fx_trap | output | 1 | Offered instruction may trap |
| fx_tag | output | TAG_W | Sequence tag for a trap-capable instruction |
| fx_op | output | OP_W | Payload to the fixed-point queue |
| fp_valid | output | 1 | Instruction offered to the floating-point queue |
| fp_ready | input | 1 | Floating-point queue can accept |
| fp_op | output | OP_W | Payload to the floating-point queue |
| res_valid | input | 1 | A trap-capable instruction has resolved |
| res_tag | input | TAG_W | Tag of the resolved instruction |
| res_trap | input | 1 | Resolved instruction trapped |
| rpt_valid | output | 1 | In-order resolution report |
| rpt_tag | output | TAG_W | Tag being reported |
| rpt_trap | output | 1 | Reported instruction trapped |
| flush | output | 1 | Discard all younger instructions |
| halted | output | 1 | Dispatch stopped after a trap |
| restart_ack | input | 1 | Resume dispatch after a trap |
| stall | output | 3 | bit0 interlock hold, bit1 load occupancy, bit2 capacity or queue full |

## Verification
The assertions assume that upstream keeps `in_valid` and its payload steady until the instruction is accepted, except that it may drop them after a flush. They also assume that `res_valid` names only a dispatched, still-unresolved tag, and names each such tag once. The bench meets both conditions. Its driver keeps the current instruction until it sees the handshake or a flush. Its resolver draws only from its own list of dispatched tags that have no resolution yet, so resolutions arrive out of order but never twice. Class 3 is never driven.

// File: rtl/dui_pkg.sv
`timescale 1ns/1ps
package dui_pkg;
  typedef enum logic [1:0] {
    CLS_ALU  = 2'd0,
    CLS_LOAD = 2'd1,
    CLS_FPA  = 2'd2,
    CLS_RSV  = 2'd3
  } cls_e;

  localparam int STALL_W  = 3;
  localparam int STL_IL   = 0;
  localparam int STL_LD   = 1;
  localparam int STL_CAP  = 2;
endpackage

// File: rtl/dui_trap_track.sv
`timescale 1ns/1ps
// Ordered window of trap-capable fixed-point instructions awaiting resolution.
module dui_trap_track #(
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             res_valid,
  input  logic [TAG_W-1:0] res_tag,
  input  logic             res_trap,
  output logic             pend_any,
  output logic             tag_full,
  output logic [TAG_W-1:0] tail_tag,
  output logic             rpt_valid,
  output logic [TAG_W-1:0] rpt_tag,
  output logic             rpt_trap,
  output logic             flush
);
  localparam int DEPTH = 1 << TAG_W;

  logic [TAG_W:0]   head_q, tail_q, occ;
  logic [DEPTH-1:0] done_q, trp_q;
  logic [TAG_W-1:0] head_idx, res_off;
  logic             res_hit;

  assign occ      = tail_q - head_q;
  assign head_idx = head_q[TAG_W-1:0];
  assign tail_tag = tail_q[TAG_W-1:0];
  assign pend_any = (occ != '0);
  assign tag_full = (occ == (TAG_W+1)'(DEPTH));

  assign rpt_valid = pend_any && done_q[head_idx];
  assign rpt_tag   = head_idx;
  assign rpt_trap  = trp_q[head_idx];
  assign flush     = rpt_valid && rpt_trap;

  // Offset of the resolved tag from the oldest entry; inside the window only.
  assign res_off = res_tag - head_idx;
  assign res_hit = res_valid && ({1'b0, res_off} < occ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      done_q <= '0;
      trp_q  <= '0;
    end else begin
      if (flush)          head_q <= tail_q;
      else if (rpt_valid) head_q <= head_q + 1'b1;
      if (alloc) begin
        tail_q           <= tail_q + 1'b1;
        done_q[tail_tag] <= 1'b0;
      end
      if (res_hit) begin
        done_q[res_tag] <= 1'b1;
        trp_q[res_tag]  <= res_trap;
      end
    end
  end
endmodule

// File: rtl/dui_ld_occ.sv
`timescale 1ns/1ps
// Counts the cycles a load keeps the fixed-point unit occupied.
module dui_ld_occ #(
  parameter int LD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = (LD_CYC < 2) ? 1 : $clog2(LD_CYC);

  logic [CW-1:0] cnt_q;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= CW'(LD_CYC - 1);
    else if (busy)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/dui_route.sv
`timescale 1ns/1ps
// Routing, interlock and stall-cause decode for one instruction slot.
module dui_route
  import dui_pkg::*;
(
  input  logic               in_valid,
  input  logic [1:0]         in_cls,
  input  logic               in_trap,
  input  logic               halt_now,
  input  logic               ld_busy,
  input  logic               pend_any,
  input  logic               tag_full,
  input  logic               fx_ready,
  input  logic               fp_ready,
  output logic               in_ready,
  output logic               fx_valid,
  output logic               fp_valid,
  output logic               fx_load,
  output logic [STALL_W-1:0] stall
);
  logic to_fx, go, fx_ok, cap_block;

  assign to_fx = (in_cls != CLS_FPA);
  assign go    = in_valid && !halt_now;
  assign fx_ok = !ld_busy && !(in_trap && tag_full);

  assign fx_valid = go && to_fx && fx_ok;
  assign fp_valid = go && !to_fx && !pend_any;
  assign fx_load  = (in_cls == CLS_LOAD);
  assign in_ready = to_fx ? (fx_valid && fx_ready) : (fp_valid && fp_ready);

  assign cap_block = to_fx ? (!fx_ready || (in_trap && tag_full)) : !fp_ready;

  always_comb begin
    stall          = '0;
    stall[STL_IL]  = go && !to_fx && pend_any;
    stall[STL_LD]  = go && to_fx && ld_busy;
    stall[STL_CAP] = go && cap_block;
  end
endmodule

// File: rtl/dui_dispatch.sv
`timescale 1ns/1ps
module dui_dispatch
  import dui_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int TAG_W  = 2,
  parameter int LD_CYC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_cls,
  input  logic               in_trap,
  input  logic [OP_W-1:0]    in_op,
  output logic               fx_valid,
  input  logic               fx_ready,
  output logic               fx_load,
  output logic               fx_trap,
  output logic [TAG_W-1:0]   fx_tag,
  output logic [OP_W-1:0]    fx_op,
  output logic               fp_valid,
  input  logic               fp_ready,
  output logic [OP_W-1:0]    fp_op,
  input  logic               res_valid,
  input  logic [TAG_W-1:0]   res_tag,
  input  logic               res_trap,
  output logic               rpt_valid,
  output logic [TAG_W-1:0]   rpt_tag,
  output logic               rpt_trap,
  output logic               flush,
  output logic               halted,
  input  logic               restart_ack,
  output logic [STALL_W-1:0] stall
);
  logic halted_q, halt_now, fx_fire;
  logic pend_any, tag_full, ld_busy;

  assign halt_now = halted_q || flush;
  assign halted   = halted_q;
  assign fx_fire  = fx_valid && fx_ready;
  assign fx_trap  = in_trap;
  assign fx_op    = in_op;
  assign fp_op    = in_op;

  dui_trap_track #(.TAG_W(TAG_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc    (fx_fire && in_trap),
    .res_valid(res_valid),
    .res_tag  (res_tag),
    .res_trap (res_trap),
    .pend_any (pend_any),
    .tag_full (tag_full),
    .tail_tag (fx_tag),
    .rpt_valid(rpt_valid),
    .rpt_tag  (rpt_tag),
    .rpt_trap (rpt_trap),
    .flush    (flush)
  );

  dui_ld_occ #(.LD_CYC(LD_CYC)) u_ld (
    .clk  (clk),
    .rst_n(rst_n),
    .start(fx_fire && fx_load),
    .busy (ld_busy)
  );

  dui_route u_route (
    .in_valid(in_valid),
    .in_cls  (in_cls),
    .in_trap (in_trap),
    .halt_now(halt_now),
    .ld_busy (ld_busy),
    .pend_any(pend_any),
    .tag_full(tag_full),
    .fx_ready(fx_ready),
    .fp_ready(fp_ready),
    .in_ready(in_ready),
    .fx_valid(fx_valid),
    .fp_valid(fp_valid),
    .fx_load (fx_load),
    .stall   (stall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           halted_q <= 1'b0;
    else if (flush)       halted_q <= 1'b1;
    else if (restart_ack) halted_q <= 1'b0;
  end
endmodule

// File: rtl/dui_dispatch_chk.sv
`timescale 1ns/1ps
module dui_dispatch_chk
  import dui_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int TAG_W  = 2,
  parameter int LD_CYC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_cls,
  input logic             fx_valid,
  input logic             fx_ready,
  input logic             fx_load,
  input logic             fx_trap,
  input logic [OP_W-1:0]  fx_op,
  input logic             fp_valid,
  input logic             fp_ready,
  input logic [OP_W-1:0]  fp_op,
  input logic             rpt_valid,
  input logic [TAG_W-1:0] rpt_tag,
  input logic             rpt_trap,
  input logic             flush,
  input logic             halted,
  input logic             restart_ack
);
  localparam int DEPTH = 1 << TAG_W;

  // Outstanding trap-capable count, kept from the handshakes alone.
  logic [TAG_W:0] outst_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      outst_q <= '0;
    else if (flush)  outst_q <= '0;
    else             outst_q <= outst_q + (TAG_W+1)'(fx_valid && fx_ready && fx_trap)
                                        - (TAG_W+1)'(rpt_valid);
  end

  AST_ONE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(fx_valid && fp_valid)); // R1
  AST_LOAD_FX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_cls == CLS_LOAD) |-> !fp_valid); // R2
  AST_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (LD_CYC > 1 && fx_valid && fx_ready && fx_load) |=> !fx_valid); // R3
  AST_FP_INTERLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    fp_valid |-> (outst_q == '0)); // R4
  AST_REPORT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_trap) |=> (!rpt_valid || rpt_tag == TAG_W'($past(rpt_tag) + 1'b1))); // R6
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!fx_valid && !fp_valid)); // R7
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart_ack) |=> halted); // R7
  AST_TAG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q <= (TAG_W+1)'(DEPTH)); // R8
  AST_FX_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (fx_valid && !fx_ready) |=> (flush || (fx_valid && $stable(fx_op)))); // R9
  AST_FP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_valid && !fp_ready) |=> (flush || (fp_valid && $stable(fp_op)))); // R9
endmodule

bind dui_dispatch dui_dispatch_chk #(.OP_W(OP_W), .TAG_W(TAG_W), .LD_CYC(LD_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_cls     (in_cls),
  .fx_valid   (fx_valid),
  .fx_ready   (fx_ready),
  .fx_load    (fx_load),
  .fx_trap    (fx_trap),
  .fx_op      (fx_op),
  .fp_valid   (fp_valid),
  .fp_ready   (fp_ready),
  .fp_op      (fp_op),
  .rpt_valid  (rpt_valid),
  .rpt_tag    (rpt_tag),
  .rpt_trap   (rpt_trap),
  .flush      (flush),
  .halted     (halted),
  .restart_ack(restart_ack)
);

// File: tb/sim_dui_dispatch.sv
`timescale 1ns/1ps
module sim_dui_dispatch;
  localparam int OP_W   = 8;
  localparam int TAG_W  = 2;
  localparam int LD_CYC = 2;
  localparam int DEPTH  = 1 << TAG_W;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_trap;
  logic [1:0] in_cls;
  logic [OP_W-1:0] in_op, fx_op, fp_op;
  logic fx_valid, fx_ready, fx_load, fx_trap;
  logic [TAG_W-1:0] fx_tag, res_tag, rpt_tag;
  logic fp_valid, fp_ready;
  logic res_valid, res_trap, rpt_valid, rpt_trap, flush, halted, restart_ack;
  logic [2:0] stall;

  always #5 clk = ~clk;

  dui_dispatch #(.OP_W(OP_W), .TAG_W(TAG_W), .LD_CYC(LD_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_trap(in_trap), .in_op(in_op),
    .fx_valid(fx_valid), .fx_ready(fx_ready), .fx_load(fx_load), .fx_trap(fx_trap),
    .fx_tag(fx_tag), .fx_op(fx_op), .fp_valid(fp_valid), .fp_ready(fp_ready),
    .fp_op(fp_op), .res_valid(res_valid), .res_tag(res_tag), .res_trap(res_trap),
    .rpt_valid(rpt_valid), .rpt_tag(rpt_tag), .rpt_trap(rpt_trap), .flush(flush),
    .halted(halted), .restart_ack(restart_ack), .stall(stall)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference state built from the requirements.
  int m_pend[$];
  bit m_done[DEPTH];
  bit m_trp[DEPTH];
  int m_tail = 0;
  int m_ld = 0;
  bit m_halt = 0;
  bit last_acc, last_flush;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_stall_cap(bit tofx, bit fr, bit pr, bit t, bit full);
    return tofx ? (!fr || (t && full)) : !pr;
  endfunction

  task automatic step(input bit v, input bit [1:0] c, input bit t, input bit [OP_W-1:0] op,
                      input bit fr, input bit pr, input bit rv, input int rtag,
                      input bit rtrap, input bit ack);
    bit rptv, rtp, fl, hn, tofx, full, go, xfx, xfp, xrdy, hit;
    int rt;
    @(negedge clk);
    in_valid = v; in_cls = c; in_trap = t; in_op = op;
    fx_ready = fr; fp_ready = pr;
    res_valid = rv; res_tag = rtag[TAG_W-1:0]; res_trap = rtrap; restart_ack = ack;
    #1;
    rptv = (m_pend.size() > 0) && m_done[m_pend[0]];
    rt   = rptv ? m_pend[0] : 0;
    rtp  = rptv && m_trp[rt];
    fl   = rptv && rtp;
    hn   = m_halt || fl;
    tofx = (c != 2'd2);
    full = (m_pend.size() == DEPTH);
    go   = v && !hn;
    xfx  = go && tofx && (m_ld == 0) && !(t && full);
    xfp  = go && !tofx && (m_pend.size() == 0);
    xrdy = tofx ? (xfx && fr) : (xfp && pr);

    chk(fx_valid == xfx, "R1 fx_valid", fx_valid, xfx);
    chk(fp_valid == xfp, "R4 fp_valid", fp_valid, xfp);
    chk(in_ready == xrdy, "R9 in_ready", in_ready, xrdy);
    chk(rpt_valid == rptv, "R6 rpt_valid", rpt_valid, rptv);
    if (rptv) begin
      chk(rpt_tag == rt[TAG_W-1:0], "R6 rpt_tag", rpt_tag, rt);
      chk(rpt_trap == rtp, "R7 rpt_trap", rpt_trap, rtp);
    end
    chk(flush == fl, "R7 flush", flush, fl);
    chk(halted == m_halt, "R7 halted", halted, m_halt);
    chk(stall[0] == (go && !tofx && m_pend.size() > 0), "R4 stall0", stall[0], go && !tofx && m_pend.size() > 0);
    chk(stall[1] == (go && tofx && m_ld > 0), "R3 stall1", stall[1], go && tofx && m_ld > 0);
    chk(stall[2] == (go && exp_stall_cap(tofx, fr, pr, t, full)), "R8 stall2",
        stall[2], go && exp_stall_cap(tofx, fr, pr, t, full));
    if (!go) chk(stall == 3'b000, "R10 stall idle", stall, 0);
    if (v && c == 2'd1) chk(!fp_valid, "R2 load on fp", fp_valid, 0);
    if (go && !tofx && m_pend.size() == 0 && pr) chk(in_ready, "R5 fp free issue", in_ready, 1);
    if (fx_valid) begin
      chk(fx_op == op, "R1 fx_op", fx_op, op);
      chk(fx_load == (c == 2'd1), "R2 fx_load", fx_load, c == 2'd1);
      if (t) chk(fx_tag == m_tail[TAG_W-1:0], "R8 fx_tag", fx_tag, m_tail);
    end
    if (fp_valid) chk(fp_op == op, "R1 fp_op", fp_op, op);

    // Effect of the coming clock edge.
    hit = 0;
    foreach (m_pend[i]) if (rv && m_pend[i] == rtag) hit = 1;
    if (fl) begin
      m_pend.delete();
      m_halt = 1;
    end else begin
      if (rptv) void'(m_pend.pop_front());
      if (ack) m_halt = 0;
    end
    if (hit) begin
      m_done[rtag] = 1;
      m_trp[rtag]  = rtrap;
    end
    if (xfx && fr && t) begin
      m_done[m_tail] = 0;
      m_pend.push_back(m_tail);
      m_tail = (m_tail + 1) % DEPTH;
    end
    if (xfx && fr && c == 2'd1) m_ld = LD_CYC - 1;
    else if (m_ld > 0) m_ld--;
    last_acc   = xrdy;
    last_flush = fl;
  endtask

  task automatic send(input bit [1:0] c, input bit t, input bit [OP_W-1:0] op);
    for (int i = 0; i < 30; i++) begin
      step(1, c, t, op, 1, 1, 0, 0, 0, 0);
      if (last_acc || last_flush) break;
    end
  endtask

  task automatic settle_reset();
    rst_n = 0;
    in_valid = 0; in_cls = 0; in_trap = 0; in_op = 0;
    fx_ready = 0; fp_ready = 0; res_valid = 0; res_tag = 0; res_trap = 0; restart_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit cv, ct;
    bit [1:0] cc;
    bit [OP_W-1:0] cop;
    void'($urandom(32'd4711));
    settle_reset();

    // Reset state (R7, R10).
    step(0, 0, 0, 8'h00, 1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 8'h00, 1, 1, 0, 0, 0, 0);

    // R4: trap-capable ALU, then FP held until the report retires.
    send(2'd0, 1, 8'h11);
    step(1, 2'd2, 0, 8'h21, 1, 1, 0, 0, 0, 0);
    step(1, 2'd2, 0, 8'h21, 1, 1, 1, 0, 0, 0);
    send(2'd2, 0, 8'h21);

    // R3: load followed by ALU sees one occupancy cycle.
    send(2'd1, 0, 8'h31);
    send(2'd0, 0, 8'h32);

    // R5: FP right after a load goes straight through.
    send(2'd1, 1, 8'h41);
    step(0, 0, 0, 8'h00, 1, 1, 1, m_pend.size() > 0 ? m_pend[0] : 0, 0, 0);
    step(0, 0, 0, 8'h00, 1, 1, 0, 0, 0, 0);
    send(2'd1, 0, 8'h42);
    send(2'd2, 0, 8'h43);

    // R8, R6, R7: fill the tags, resolve youngest first, third one traps.
    for (int k = 0; k < DEPTH; k++) send(2'd0, 1, 8'h50 + 8'(k));
    step(1, 2'd0, 1, 8'h5f, 1, 1, 0, 0, 0, 0);
    for (int k = DEPTH - 1; k >= 0; k--)
      step(1, 2'd0, 1, 8'h5f, 1, 1, 1, m_pend[k], (k == 2), 0);
    for (int k = 0; k < 6; k++) step(0, 0, 0, 8'h00, 1, 1, 0, 0, 0, 0);
    step(1, 2'd2, 0, 8'h60, 1, 1, 0, 0, 0, 1);
    send(2'd2, 0, 8'h61);

    // Constrained random phase.
    cv = 0; cc = 0; ct = 0; cop = 0;
    for (int n = 0; n < 4000; n++) begin
      int cand[$];
      bit rv, rtp, ack;
      int rtag;
      if (!cv) begin
        cv  = ($urandom % 5) != 0;
        cc  = 2'($urandom % 3);
        ct  = ($urandom % 3) == 0;
        cop = OP_W'($urandom);
      end
      foreach (m_pend[i]) if (!m_done[m_pend[i]]) cand.push_back(m_pend[i]);
      rv = 0; rtag = 0; rtp = 0;
      if (cand.size() > 0 && ($urandom % 3) == 0) begin
        rv   = 1;
        rtag = cand[$urandom % cand.size()];
        rtp  = ($urandom % 12) == 0;
      end
      ack = m_halt && (($urandom % 3) == 0);
      step(cv, cc, ct, cop, ($urandom % 4) != 0, ($urandom % 4) != 0, rv, rtag, rtp, ack);
      if (last_acc || last_flush || !cv) cv = 0;
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule